// File: doc/BRIEF.md
# GPIO Interrupt Source Selector

This block turns a wide bank of asynchronous GPIO inputs into 32 interrupt requests for a parent interrupt controller. Each of the 32 slots picks any one GPIO input through a source index. The slot's enable bit sits next to that index in the same byte. A 2-bit sense field sets how the selected input is watched: rising edge, falling edge, high level or low level. Software programs and reads the block through a flat 32-bit register port.

An edge-mode event sets a sticky per-slot status bit, and software clears it by writing zero to that bit. In level mode the status bit tracks the selected input directly. A mask register sits between the status bits and the slot outputs. A slot drives its active-high request when its status is set, its enable is 1 and its mask bit is 0.

The GPIO inputs pass through a two-flop synchroniser before selection. Any write to a slot's select byte or sense field restarts that slot's edge history, so a change of source or mode cannot produce an event of its own.

Top module: `gpio_irq_selector`

## Requirements
- R1: After reset the status register reads 0, every select and sense register reads 0, the mask register reads 0xFFFFFFFF and `irq_out` is 0.
- R2: Slot k's select byte is in the register at 0x30 + 4*(k/4), byte lane k mod 4. Bit 7 of the byte is the slot enable and bits 6:0 are the source index (0..127). The byte reads back as written.
- R3: Slots 0..15 take their sense field from the register at 0x24 and slots 16..31 from 0x28, at bits 2*(k mod 16)+1 : 2*(k mod 16). The fields read back as written.
- R4: With sense code 0 (rising edge), a 0-to-1 change of the selected input sets the slot's status bit in register 0x20.
- R5: With sense code 1 (falling edge), a 1-to-0 change of the selected input sets the slot's status bit.
- R6: With sense code 2 (high level) the status bit equals the enabled slot's input, and with code 3 (low level) it equals the inverted input. A change takes three clock edges to appear.
- R7: A slot whose enable bit is 0 never gets a new status bit. Clearing the enable leaves an already set edge status unchanged.
- R8: In edge modes, writing 0 to a status bit at 0x20 clears it and writing 1 leaves it unchanged.
- R9: The mask register is at 0x10020 and 1 masks the slot. `irq_out[k]` = status[k] AND enable[k] AND NOT mask[k].
- R10: A write to a slot's select byte or sense field restarts its edge history. A changed source whose level differs from the old source raises no event, and later edges are detected normally.
- R11: GPIO inputs pass through two synchroniser flops. An input driven before clock edge e0 sets an edge status after edge e2 and not earlier.
- R12: Reads of unmapped addresses return 0 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_in | input | 2**SRC_W | Asynchronous GPIO inputs |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 32 | Active-high level requests to the parent controller |

## Verification
The bench uses the defaults SRC_W = 7 and ADDR_W = 17. This gives the full 128-input bank, so source index 127 on slot 31 is exercised. It also makes the high mask address 0x10020 decodable next to the low-address registers. A vector table runs all four sense codes on one slot across steady and changing inputs. Directed cases then cover the synchroniser latency edge by edge, the history restart on a source change, the enable and mask gating, and the handling of unmapped addresses.

// File: rtl/gpio_irq_selector.sv
module gpio_irq_selector #(
  parameter int SRC_W  = 7,
  parameter int ADDR_W = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<SRC_W)-1:0]   gpio_in,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [31:0]             irq_out
);
  localparam int NG    = 1 << SRC_W;
  localparam int NSLOT = 32;
  localparam int NSEL  = NSLOT / 4;
  localparam int GW    = $clog2(NSEL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(32'h20);
  localparam logic [ADDR_W-1:0] A_SNS0 = ADDR_W'(32'h24);
  localparam logic [ADDR_W-1:0] A_SNS1 = ADDR_W'(32'h28);
  localparam logic [ADDR_W-1:0] A_SEL0 = ADDR_W'(32'h30);
  localparam logic [ADDR_W-1:0] A_SELN = ADDR_W'(32'h30 + 4 * (NSEL - 1));
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(32'h10020);

  logic [NG-1:0]    s1_q, s2_q;
  logic [7:0]       sel_q [NSLOT];
  logic [1:0]       sns_q [NSLOT];
  logic [NSLOT-1:0] stat_q, mask_q, prev_q, valid_q;
  logic [NSLOT-1:0] cur_v, en_v, lvl_v, set_v, stat_d, sel_wr_v, sns_wr_v, cfg_wr_v;

  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_sns0 = bus_wr && bus_addr == A_SNS0;
  wire wr_sns1 = bus_wr && bus_addr == A_SNS1;
  wire wr_mask = bus_wr && bus_addr == A_MASK;
  wire sel_hit = bus_addr >= A_SEL0 && bus_addr <= A_SELN && bus_addr[1:0] == 2'b00;
  wire [ADDR_W-1:0] sel_off = bus_addr - A_SEL0;
  wire [GW-1:0]     sel_grp = sel_off[GW+1:2];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic rise, fall;
    assign sel_wr_v[k] = bus_wr && sel_hit && sel_grp == GW'(k / 4);
    assign sns_wr_v[k] = (k < 16) ? wr_sns0 : wr_sns1;
    assign cfg_wr_v[k] = sel_wr_v[k] | sns_wr_v[k];
    assign en_v[k]     = sel_q[k][7];
    assign cur_v[k]    = s2_q[sel_q[k][SRC_W-1:0]];
    assign lvl_v[k]    = sns_q[k][1];
    assign rise        = valid_q[k] & cur_v[k] & ~prev_q[k];
    assign fall        = valid_q[k] & ~cur_v[k] & prev_q[k];
    assign set_v[k]    = en_v[k] & ~lvl_v[k] & (sns_q[k][0] ? fall : rise);
    assign stat_d[k]   = lvl_v[k] ? (en_v[k] & (cur_v[k] ^ sns_q[k][0]))
                                  : (set_v[k] | (stat_q[k] & ~(wr_stat & ~bus_wdata[k])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q    <= '0;
      s2_q    <= '0;
      stat_q  <= '0;
      prev_q  <= '0;
      valid_q <= '0;
      mask_q  <= '1;
      for (int k = 0; k < NSLOT; k++) begin
        sel_q[k] <= '0;
        sns_q[k] <= '0;
      end
    end else begin
      s1_q    <= gpio_in;
      s2_q    <= s1_q;
      stat_q  <= stat_d;
      prev_q  <= cur_v;
      valid_q <= ~cfg_wr_v;
      if (wr_mask) mask_q <= bus_wdata;
      for (int k = 0; k < NSLOT; k++) begin
        if (sel_wr_v[k]) sel_q[k] <= bus_wdata[8*(k%4) +: 8];
        if (sns_wr_v[k]) sns_q[k] <= bus_wdata[2*(k%16) +: 2];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT) bus_rdata = stat_q;
    else if (bus_addr == A_MASK) bus_rdata = mask_q;
    else if (bus_addr == A_SNS0 || bus_addr == A_SNS1) begin
      for (int k = 0; k < 16; k++)
        bus_rdata[2*k +: 2] = (bus_addr == A_SNS0) ? sns_q[k] : sns_q[k+16];
    end else if (sel_hit) begin
      for (int j = 0; j < 4; j++)
        bus_rdata[8*j +: 8] = sel_q[4*int'(sel_grp) + j];
    end
  end

  assign irq_out = stat_q & en_v & ~mask_q;

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(en_v)) == '0)); // R7
  AST_W0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & ~$past(bus_wdata) & ~$past(lvl_v) & ~$past(set_v)) == '0)); // R8
  AST_HIST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_wr_v) |-> ##2 ((stat_q & ~$past(stat_q) & ~lvl_v & $past(cfg_wr_v, 2)) == '0)); // R10
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q)); // R9
endmodule

// File: tb/gpio_irq_selector_test.sv
`timescale 1ns/1ps
module gpio_irq_selector_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [127:0] gpio = '0;
  logic [16:0]  bus_addr = '0;
  logic         bus_wr = 0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata, irq_out;
  int checks = 0, failures = 0;

  gpio_irq_selector uut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #5 clk = ~clk;

  // {sense[1:0], before, after, expected status}
  localparam logic [4:0] VEC [9] = '{
    5'b00_0_1_1, 5'b00_1_0_0, 5'b00_1_1_0,
    5'b01_1_0_1, 5'b01_0_1_0,
    5'b10_0_1_1, 5'b10_1_0_0,
    5'b11_1_0_1, 5'b11_0_1_0};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("TIMEOUT watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    step(3);
    rst_n = 1;
    step(1);
    rd(17'h20, d);    chk("R1 status", d, 0);
    rd(17'h10020, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(17'h30, d);    chk("R1 select", d, 0);
    rd(17'h24, d);    chk("R1 sense", d, 0);
    chk("R1 irq_out", irq_out, 0);

    // slot 3: enable, source 10
    wr(17'h30, 32'h8A00_0000);
    foreach (VEC[i]) begin
      gpio[10] = VEC[i][2];
      wr(17'h24, {24'h0, VEC[i][4:3], 6'h0});
      step(6);
      wr(17'h20, 32'hFFFF_FFF7);
      step(2);
      gpio[10] = VEC[i][1];
      step(5);
      rd(17'h20, d);
      chk($sformatf("R4 R5 R6 vector %0d", i), {31'h0, d[3]}, {31'h0, VEC[i][0]});
    end

    // R11 latency, rising mode
    wr(17'h24, 0);
    gpio[10] = 0;
    step(6);
    wr(17'h20, 32'hFFFF_FFF7);
    step(2);
    gpio[10] = 1;
    step(2); rd(17'h20, d); chk("R11 before e2", {31'h0, d[3]}, 0);
    step(1); rd(17'h20, d); chk("R11 after e2", {31'h0, d[3]}, 1);

    // R9 mask gating
    chk("R9 masked", {31'h0, irq_out[3]}, 0);
    wr(17'h10020, 32'hFFFF_FFF7);
    chk("R9 unmasked", {31'h0, irq_out[3]}, 1);
    rd(17'h10020, d); chk("R9 mask readback", d, 32'hFFFF_FFF7);
    wr(17'h30, 32'h0A00_0000);
    chk("R9 enable off", {31'h0, irq_out[3]}, 0);
    rd(17'h20, d); chk("R7 status kept", {31'h0, d[3]}, 1);

    // R8 clear semantics
    wr(17'h20, 32'hFFFF_FFFF); step(1);
    rd(17'h20, d); chk("R8 write one keeps", {31'h0, d[3]}, 1);
    wr(17'h20, 32'hFFFF_FFF7); step(1);
    rd(17'h20, d); chk("R8 write zero clears", {31'h0, d[3]}, 0);

    // R7 disabled slot ignores an edge
    gpio[10] = 0; step(5);
    gpio[10] = 1; step(5);
    rd(17'h20, d); chk("R7 disabled", {31'h0, d[3]}, 0);
    chk("R7 irq_out", {31'h0, irq_out[3]}, 0);

    // R10 history restart, slot 20 (reg 0x44 lane 0, sense 0x28 bits 9:8)
    gpio[40] = 0; gpio[41] = 1;
    wr(17'h28, 0);
    wr(17'h44, 32'h0000_00A8);
    step(6);
    wr(17'h20, ~(32'h1 << 20));
    step(2);
    wr(17'h44, 32'h0000_00A9);
    step(6);
    rd(17'h20, d); chk("R10 no spurious event", {31'h0, d[20]}, 0);
    gpio[41] = 0; step(5);
    gpio[41] = 1; step(5);
    rd(17'h20, d); chk("R10 R4 later edge seen", {31'h0, d[20]}, 1);

    // R2 R3 R5 slot 31, source 127, falling
    gpio[127] = 1;
    wr(17'h4C, 32'hFF00_0000);
    wr(17'h28, 32'h4000_0000);
    step(6);
    wr(17'h20, 32'h7FFF_FFFF);
    step(2);
    gpio[127] = 0;
    step(5);
    rd(17'h20, d); chk("R5 slot31 src127", {31'h0, d[31]}, 1);
    rd(17'h4C, d); chk("R2 select readback", d, 32'hFF00_0000);
    rd(17'h28, d); chk("R3 sense readback", d, 32'h4000_0000);
    rd(17'h44, d); chk("R2 lane0 readback", d, 32'h0000_00A9);

    // R12 unmapped addresses
    rd(17'h2C, d); chk("R12 read 0x2C", d, 0);
    rd(17'h50, d); chk("R12 read 0x50", d, 0);
    wr(17'h50, 32'hFFFF_FFFF);
    wr(17'h10024, 32'h0);
    rd(17'h4C, d); chk("R12 select untouched", d, 32'hFF00_0000);
    rd(17'h10020, d); chk("R12 mask untouched", d, 32'hFFFF_FFF7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule